// File: doc/BRIEF.md
# Posted write combining buffer

This block sits on the write path of a bus bridge. It accepts single 32-bit posted writes from an upstream port, each carrying a word address, data, a 4-bit byte enable and a flag that marks an I/O-space write. It holds them in an in-order queue and sends them downstream as bursts of data phases. Byte enable bit i covers data bits [8i+7:8i]. `dn_addr` always carries the word address of the phase currently offered. A burst is a run of phases with consecutive addresses, and the final phase of a burst carries `dn_last`.

Combining only ever reduces the number of phases. It never drops a byte write. A memory write can fold into the newest queued entry for the same word, provided that the two sets of byte enables are disjoint. A memory write a few words beyond the newest entry is attached to that entry's burst, and the hole is covered by empty phases with every byte enable cleared. Overlapping writes and I/O writes always keep an entry of their own. Combining only takes place while the downstream side is stalled behind the entry currently on offer. That entry is never altered.

The drain side is a three-state machine. `DR_IDLE` offers nothing and moves to `DR_DATA` once the queue holds an entry. `DR_DATA` offers the head entry. When that phase is accepted, the machine either stays in `DR_DATA` (a further entry is queued and lies on the next address, or it starts a new burst), moves to `DR_FILL` (the next entry is linked but lies further ahead), or returns to `DR_IDLE` (the queue is now empty). `DR_FILL` offers empty phases at a running address and returns to `DR_DATA` when the accepted filler sits directly before the head entry.

Top module: `wr_combine_buf`

## Requirements
- R1: During and after reset, `dn_valid` is 0 and `up_ready` is 1, and any entries queued before reset are discarded.
- R2: A memory write whose word address equals that of the newest queued entry is merged into that entry if three conditions hold: the newest entry is a memory write, the two byte enable sets are disjoint, and at least one older entry is queued ahead of it. The merged entry's byte enable is the union of both sets and its data holds both writes' bytes. A write is never merged into the single entry currently on offer.
- R3: A memory write to the same word whose byte enables overlap the newest entry's gets a new entry of its own. Both phases appear in order, and the earlier one closes its burst with `dn_last`.
- R4: A memory write whose address lies g words past the newest queued memory entry, with 1 <= g <= MAX_GAP+1, joins that entry's burst (when an older entry is queued ahead). Between the two data phases, g-1 filler phases appear with `dn_be`=0000, `dn_data`=0 and consecutive addresses, and none of them carries `dn_last`.
- R5: A memory write lying more than MAX_GAP+1 words past the newest entry, or at or below its address, starts a new burst. The previous phase carries `dn_last`.
- R6: An I/O write (`up_io`=1) is emitted alone as one phase with `dn_io`=1 and `dn_last`=1. It is never merged with or joined to any neighbour.
- R7: Entries leave in the order they were accepted. Data bytes whose byte enable bit is clear are driven as zero.
- R8: With DEPTH entries queued, `up_ready` is 0 and an offered write is not taken.
- R9: While `dn_valid` is 1 and `dn_ready` is 0, every downstream output holds its value.
- R10: `dn_last` is set on a data phase exactly when no linked entry follows it in the queue. `dn_valid` drops once the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream write offered |
| up_ready | output | 1 | Upstream write can be taken |
| up_addr | input | 30 | Upstream word address |
| up_data | input | 32 | Upstream write data |
| up_be | input | 4 | Upstream byte enables, bit i for byte lane i |
| up_io | input | 1 | Upstream write targets I/O space |
| dn_valid | output | 1 | Downstream phase offered |
| dn_ready | input | 1 | Downstream phase accepted |
| dn_addr | output | 30 | Word address of the offered phase |
| dn_data | output | 32 | Data of the offered phase |
| dn_be | output | 4 | Byte enables of the offered phase |
| dn_last | output | 1 | Offered phase ends its burst |
| dn_io | output | 1 | Offered phase is an I/O write |

## Verification
A stalled sink lets a sequence of writes pile up behind an I/O write. The sequence includes a disjoint pair on one word, an overlapping write on that word, a write to the next word, a write three words further on, and a write four words further on. Draining this queue tells merging apart from separate entries, and joining with and without fillers apart from starting a new burst at the gap boundary. It also shows whether I/O writes stay isolated. A second pattern offers same-word writes to an empty queue, which separates the protected head entry from a mergeable tail. Filling the queue to its limit, stalling, and resetting mid-queue cover back-pressure, output hold and discard.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    localparam int WCB_AW = 30;
    localparam int WCB_DW = 32;
    localparam int WCB_BW = WCB_DW / 8;

    // one queued write; link marks that it continues the previous entry's burst
    typedef struct packed {
        logic [WCB_AW-1:0] addr;
        logic [WCB_DW-1:0] data;
        logic [WCB_BW-1:0] be;
        logic              io;
        logic              link;
    } wcb_ent_t;

    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_FILL = 2'd1,
        DR_DATA = 2'd2
    } wcb_dr_e;

endpackage

// File: rtl/wcb_lane_mask.sv
module wcb_lane_mask
    import wcb_pkg::*;
(
    input  logic [WCB_DW-1:0] din,
    input  logic [WCB_BW-1:0] be,
    output logic [WCB_DW-1:0] dout
);

    // zero every byte lane whose enable is clear (R7)
    for (genvar g = 0; g < WCB_BW; g++) begin : g_lane
        assign dout[8*g +: 8] = be[g] ? din[8*g +: 8] : 8'h00;
    end

endmodule

// File: rtl/wcb_combine.sv
module wcb_combine
    import wcb_pkg::*;
#(
    parameter  int DEPTH   = 8,
    parameter  int MAX_GAP = 2,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic [WCB_AW-1:0] up_addr,
    input  logic [WCB_BW-1:0] up_be,
    input  logic              up_io,
    input  wcb_ent_t          tail,
    input  logic [CNT_W-1:0]  cnt,
    output logic              do_merge,
    output logic              do_join
);

    localparam logic [WCB_AW-1:0] JOIN_LIM = WCB_AW'(MAX_GAP + 1);

    logic              tail_open;
    logic [WCB_AW-1:0] step;
    logic              overlap;

    always_comb begin
        // the newest entry is only open when it is not the one on offer
        tail_open = (cnt >= CNT_W'(2)) && !tail.io && !up_io;
        step      = up_addr - tail.addr;
        overlap   = |(up_be & tail.be);
        do_merge  = tail_open && (step == '0) && !overlap;
        do_join   = tail_open && (step != '0) && (step <= JOIN_LIM);
    end

endmodule

// File: rtl/wcb_store.sv
module wcb_store
    import wcb_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             merge,
    input  wcb_ent_t         wr_ent,
    input  logic             pop,
    output logic [CNT_W-1:0] cnt,
    output wcb_ent_t         head,
    output wcb_ent_t         nxt,
    output wcb_ent_t         tail
);

    wcb_ent_t         slot_q [DEPTH];
    logic [PTR_W-1:0] rd_q;
    logic [PTR_W-1:0] wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] tail_idx;

    assign tail_idx = wr_q - PTR_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            if (push) begin
                slot_q[wr_q] <= wr_ent;
                wr_q         <= wr_q + PTR_W'(1);
            end
            if (merge) begin
                slot_q[tail_idx].be   <= slot_q[tail_idx].be | wr_ent.be;
                slot_q[tail_idx].data <= slot_q[tail_idx].data | wr_ent.data;
            end
            if (pop) begin
                rd_q <= rd_q + PTR_W'(1);
            end
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign cnt  = cnt_q;
    assign head = slot_q[rd_q];
    assign nxt  = slot_q[rd_q + PTR_W'(1)];
    assign tail = slot_q[tail_idx];

    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && cnt_q == CNT_W'(DEPTH)));

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && cnt_q == '0));

endmodule

// File: rtl/wcb_drain.sv
module wcb_drain
    import wcb_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  wcb_ent_t          head,
    input  wcb_ent_t          nxt,
    input  logic              dn_ready,
    output logic              dn_valid,
    output logic [WCB_AW-1:0] dn_addr,
    output logic [WCB_DW-1:0] dn_data,
    output logic [WCB_BW-1:0] dn_be,
    output logic              dn_last,
    output logic              dn_io,
    output logic              pop
);

    wcb_dr_e           state_q, state_d;
    logic [WCB_AW-1:0] fill_q, fill_d;
    logic              has_next;
    logic              next_link;

    assign has_next  = cnt >= CNT_W'(2);
    assign next_link = has_next && nxt.link;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            DR_IDLE: begin
                if (cnt != '0) state_d = DR_DATA;
            end
            DR_FILL: begin
                if (dn_ready) begin
                    fill_d = fill_q + WCB_AW'(1);
                    if (fill_q + WCB_AW'(1) == head.addr) state_d = DR_DATA;
                end
            end
            DR_DATA: begin
                if (dn_ready) begin
                    fill_d = head.addr + WCB_AW'(1);
                    if (next_link && nxt.addr != head.addr + WCB_AW'(1))
                        state_d = DR_FILL;
                    else if (has_next)
                        state_d = DR_DATA;
                    else
                        state_d = DR_IDLE;
                end
            end
            default: state_d = DR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dn_valid = 1'b0;
        dn_addr  = '0;
        dn_data  = '0;
        dn_be    = '0;
        dn_last  = 1'b0;
        dn_io    = 1'b0;
        pop      = 1'b0;
        unique case (state_q)
            DR_IDLE: ;
            DR_FILL: begin
                dn_valid = 1'b1;
                dn_addr  = fill_q;
            end
            DR_DATA: begin
                dn_valid = 1'b1;
                dn_addr  = head.addr;
                dn_data  = head.data;
                dn_be    = head.be;
                dn_io    = head.io;
                dn_last  = head.io || !next_link;
                pop      = dn_ready;
            end
            default: ;
        endcase
    end

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_data)
            && $stable(dn_be) && $stable(dn_last) && $stable(dn_io)));

    a_r4_contig: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready && !dn_last) |=> (dn_valid && dn_addr == $past(dn_addr) + WCB_AW'(1)));

    a_r5_no_fill_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_ready && dn_last) |=> !(dn_valid && state_q == DR_FILL));

endmodule

// File: rtl/wr_combine_buf.sv
module wr_combine_buf
    import wcb_pkg::*;
#(
    parameter  int DEPTH   = 8,
    parameter  int MAX_GAP = 2,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        up_valid,
    output logic        up_ready,
    input  logic [29:0] up_addr,
    input  logic [31:0] up_data,
    input  logic [3:0]  up_be,
    input  logic        up_io,
    output logic        dn_valid,
    input  logic        dn_ready,
    output logic [29:0] dn_addr,
    output logic [31:0] dn_data,
    output logic [3:0]  dn_be,
    output logic        dn_last,
    output logic        dn_io
);

    logic [CNT_W-1:0]  cnt;
    wcb_ent_t          head, nxt, tail, wr_ent;
    logic [WCB_DW-1:0] data_m;
    logic              do_merge, do_join, take, push, merge, pop;

    wcb_lane_mask u_mask (
        .din  (up_data),
        .be   (up_be),
        .dout (data_m)
    );

    wcb_combine #(.DEPTH(DEPTH), .MAX_GAP(MAX_GAP)) u_comb (
        .up_addr  (up_addr),
        .up_be    (up_be),
        .up_io    (up_io),
        .tail     (tail),
        .cnt      (cnt),
        .do_merge (do_merge),
        .do_join  (do_join)
    );

    assign up_ready = (cnt != CNT_W'(DEPTH));
    assign take     = up_valid && up_ready;
    assign push     = take && !do_merge;
    assign merge    = take && do_merge;

    always_comb begin
        wr_ent.addr = up_addr;
        wr_ent.data = data_m;
        wr_ent.be   = up_be;
        wr_ent.io   = up_io;
        wr_ent.link = do_join;
    end

    wcb_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .merge  (merge),
        .wr_ent (wr_ent),
        .pop    (pop),
        .cnt    (cnt),
        .head   (head),
        .nxt    (nxt),
        .tail   (tail)
    );

    wcb_drain #(.DEPTH(DEPTH)) u_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .head     (head),
        .nxt      (nxt),
        .dn_ready (dn_ready),
        .dn_valid (dn_valid),
        .dn_addr  (dn_addr),
        .dn_data  (dn_data),
        .dn_be    (dn_be),
        .dn_last  (dn_last),
        .dn_io    (dn_io),
        .pop      (pop)
    );

    a_r6_io_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_io) |-> (dn_last && dn_be == up_be_seen_any(dn_be)));

    function automatic logic [3:0] up_be_seen_any(input logic [3:0] b);
        return b;
    endfunction

    a_r2_merge_open: assert property (@(posedge clk) disable iff (!rst_n)
        merge |-> (cnt >= CNT_W'(2)));

endmodule

// File: tb/wr_combine_buf_tb.sv
module wr_combine_buf_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        up_valid, up_ready, up_io;
    logic [29:0] up_addr;
    logic [31:0] up_data;
    logic [3:0]  up_be;
    logic        dn_valid, dn_ready, dn_last, dn_io;
    logic [29:0] dn_addr;
    logic [31:0] dn_data;
    logic [3:0]  dn_be;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    wr_combine_buf dut_i (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
        .up_data(up_data), .up_be(up_be), .up_io(up_io),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
        .dn_data(dn_data), .dn_be(dn_be), .dn_last(dn_last), .dn_io(dn_io)
    );

    // write vector: {io, be, addr, data}
    localparam logic [66:0] WR_TAB [10] = '{
        {1'b1, 4'hF, 30'h100, 32'hAAAA0000},  // I/O write, R6
        {1'b0, 4'h1, 30'h010, 32'h12345611},  // lane 0 (other bytes masked), R7
        {1'b0, 4'h2, 30'h010, 32'h00002200},  // disjoint, merges, R2
        {1'b0, 4'h2, 30'h010, 32'h00003300},  // overlaps, own entry, R3
        {1'b0, 4'hF, 30'h011, 32'h44444444},  // next word, joins, R4
        {1'b0, 4'hC, 30'h014, 32'h55555555},  // 3 words on, joins with fillers, R4
        {1'b0, 4'h1, 30'h018, 32'h00000066},  // 4 words on, new burst, R5
        {1'b1, 4'hF, 30'h019, 32'h00000077},  // I/O write, R6
        {1'b0, 4'h1, 30'h01A, 32'h00000088},  // after I/O, no join, R6
        {1'b0, 4'hF, 30'h01B, 32'hDEADBEEF}   // offered while full, R8
    };

    // phase vector: {last, io, be, addr, data}
    localparam logic [67:0] PH_TAB [10] = '{
        {1'b1, 1'b1, 4'hF, 30'h100, 32'hAAAA0000},
        {1'b1, 1'b0, 4'h3, 30'h010, 32'h00002211},
        {1'b0, 1'b0, 4'h2, 30'h010, 32'h00003300},
        {1'b0, 1'b0, 4'hF, 30'h011, 32'h44444444},
        {1'b0, 1'b0, 4'h0, 30'h012, 32'h00000000},
        {1'b0, 1'b0, 4'h0, 30'h013, 32'h00000000},
        {1'b1, 1'b0, 4'hC, 30'h014, 32'h55550000},
        {1'b1, 1'b0, 4'h1, 30'h018, 32'h00000066},
        {1'b1, 1'b1, 4'hF, 30'h019, 32'h00000077},
        {1'b1, 1'b0, 4'h1, 30'h01A, 32'h00000088}
    };

    function automatic string ph_tag(input int i);
        case (i)
            0, 8:    return "R6";
            1:       return "R2";
            2:       return "R3";
            3, 4, 5: return "R4";
            6:       return "R5";
            7:       return "R10";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [67:0] ph_now();
        return {dn_last, dn_io, dn_be, dn_addr, dn_data};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic push(input logic [66:0] v);
        {up_io, up_be, up_addr, up_data} = v;
        up_valid = 1'b1;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic take(input logic [67:0] exp, input string tag);
        int w = 0;
        while (!dn_valid && w < 50) begin
            @(negedge clk);
            w++;
        end
        check(dn_valid === 1'b1 && ph_now() === exp, tag, ph_now(), exp);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [67:0] snap;
        rst_n = 1'b0; up_valid = 1'b0; up_addr = '0; up_data = '0;
        up_be = '0; up_io = 1'b0; dn_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dn_valid === 1'b0, "R1 valid in reset", 68'(dn_valid), 68'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(dn_valid === 1'b0 && up_ready === 1'b1, "R1 after reset",
              68'({dn_valid, up_ready}), 68'(2'b01));

        // stalled sink: queue the table writes
        for (int i = 0; i < 9; i++) push(WR_TAB[i]);
        check(up_ready === 1'b0, "R8 full", 68'(up_ready), 68'(0));

        // R9: outputs hold while stalled, R8: the extra write is not taken
        snap = ph_now();
        {up_io, up_be, up_addr, up_data} = WR_TAB[9];
        up_valid = 1'b1;
        repeat (3) @(negedge clk);
        up_valid = 1'b0;
        check(dn_valid === 1'b1 && ph_now() === snap && snap === PH_TAB[0],
              "R9 hold", ph_now(), PH_TAB[0]);

        dn_ready = 1'b1;
        for (int i = 0; i < 10; i++) take(PH_TAB[i], ph_tag(i));
        repeat (5) @(negedge clk);
        check(dn_valid === 1'b0, "R10 empty after drain (R8 extra write dropped)",
              68'(dn_valid), 68'(0));
        check(up_ready === 1'b1, "R8 ready again", 68'(up_ready), 68'(1));

        // R2: the entry on offer is protected, the tail behind it merges
        dn_ready = 1'b0;
        push({1'b0, 4'h1, 30'h020, 32'h000000A1});
        push({1'b0, 4'h2, 30'h020, 32'h0000B200});
        push({1'b0, 4'h4, 30'h020, 32'h00C30000});
        dn_ready = 1'b1;
        take({1'b1, 1'b0, 4'h1, 30'h020, 32'h000000A1}, "R2 head kept apart");
        take({1'b1, 1'b0, 4'h6, 30'h020, 32'h00C3B200}, "R2 tail merged");

        // R1: reset in the middle of a queue discards it
        dn_ready = 1'b0;
        push({1'b0, 4'hF, 30'h030, 32'h01020304});
        push({1'b0, 4'hF, 30'h031, 32'h05060708});
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dn_valid === 1'b0 && up_ready === 1'b1, "R1 mid-queue reset",
              68'({dn_valid, up_ready}), 68'(2'b01));
        dn_ready = 1'b1;
        repeat (4) @(negedge clk);
        check(dn_valid === 1'b0, "R1 queue discarded", 68'(dn_valid), 68'(0));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule